// File: doc/BRIEF.md
# Page Write Buffer and Commit

This block gathers the data bytes of one write transaction into a latch that holds exactly one row of a byte-addressed array, then moves them into the array in one self-timed programming interval. The upstream protocol logic supplies a start address, then strobes one data byte at a time. Only the column part of the address advances, so a long burst circles back to the start of the same row and replaces bytes it latched earlier. Each latch entry has a valid flag, so only the columns that were actually loaded reach the array.

A commit request starts a programming interval whose length is a parameter counted in system clocks. The busy flag stays high for the whole interval. While it is high the block ignores every load, abort and commit request. The latched bytes are copied into the array, one entry per clock, during the last row-length cycles of that interval. Busy drops in the same cycle as the final copy, and the latch becomes empty. An abort request empties the latch and does not touch the array. A read port gives combinational access to the array, which comes out of reset with every byte at FFh.

Top module: `pgw_page_commit`

## Requirements
- R1: While reset is held and after it is released, `busy` is low and every array byte reads FFh. Requests are accepted from the third clock edge after `rst_n` rises.
- R2: A start pulse takes the row from address bits ADDR_W-1..7 and the column from bits 6..0. Each byte strobe latches its byte at the current column and then advances the column by one.
- R3: Past column 127 the column returns to column 0 of the same row. Bytes loaded later replace the ones that were latched there earlier.
- R4: A commit writes each latched entry to row*128+column and leaves every other array byte unchanged.
- R5: Every accepted commit, even one with nothing latched, raises `busy` after the accepting edge and holds it high for exactly BUSY_CYCLES cycles. The array holds its final contents once `busy` has fallen.
- R6: While `busy` is high, start, byte, abort and commit requests have no effect.
- R7: An abort while idle discards all latched bytes. It leaves the array unchanged and does not raise `busy`.
- R8: The column pointer survives a commit. Bytes loaded after a commit without a new start continue at the next column, and the next commit writes only those bytes.
- R9: A new start discards every byte latched since the previous start that was not yet committed.
- R10: A single byte loaded and committed changes exactly one array location.
- R11: When requests arrive in the same cycle, abort wins over commit and commit wins over loading. Requests that lose have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ld_start | input | 1 | Begin a new transaction at `ld_addr` |
| ld_addr | input | ADDR_W | Start address: row in the upper bits, column in bits 6..0 |
| ld_byte | input | 1 | Latch `ld_data` at the current column |
| ld_data | input | DATA_W | Data byte to latch |
| commit_req | input | 1 | Start the programming interval |
| abort_req | input | 1 | Discard the latched bytes |
| busy | output | 1 | Programming interval in progress |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Array byte at `rd_addr` (combinational) |

## Verification
Errors in the valid flags or the column pointer appear only once `busy` falls. They show up as array bytes that are missing, stale, or written at the wrong column, so the bench reads the whole array back after each commit. A sequencer that counts wrongly changes how long `busy` stays high, so the bench counts every busy cycle of every commit. A request that slips through during busy corrupts the row that is being committed, so the bench sees it at the read port in that same commit.

// File: rtl/pgw_pkg.sv
`timescale 1ns/1ps
package pgw_pkg;
  // Commit sequencer phases
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_WAIT  = 2'd1,
    SEQ_WRITE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/pgw_byte_array.sv
`timescale 1ns/1ps
module pgw_byte_array #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0][DATA_W-1:0] mem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '1;
    end else if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_addr];

  // R4
  array_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem_q));

endmodule

// File: rtl/pgw_page_latch.sv
`timescale 1ns/1ps
module pgw_page_latch #(
  parameter int ROW_W  = 2,
  parameter int COL_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_en,
  input  logic [ROW_W+COL_W-1:0] start_addr,
  input  logic                   byte_en,
  input  logic [DATA_W-1:0]      byte_data,
  input  logic                   clr_all,
  input  logic [COL_W-1:0]       scan_idx,
  output logic [ROW_W-1:0]       row_o,
  output logic [DATA_W-1:0]      scan_data,
  output logic                   scan_valid
);
  localparam int ENTRIES = 1 << COL_W;

  logic [ROW_W-1:0]                row_q, row_d;
  logic [COL_W-1:0]                col_q, col_d, wcol;
  logic [ENTRIES-1:0]              valid_q, valid_d;
  logic [ENTRIES-1:0][DATA_W-1:0]  data_q;

  // Next state of pointer and flags
  always_comb begin
    wcol    = start_en ? start_addr[COL_W-1:0] : col_q;
    row_d   = row_q;
    col_d   = col_q;
    valid_d = valid_q;
    if (start_en) begin
      row_d   = start_addr[ROW_W+COL_W-1:COL_W];
      col_d   = wcol;
      valid_d = '0;
    end
    if (byte_en) begin
      valid_d[wcol] = 1'b1;
      col_d         = wcol + COL_W'(1);
    end
    if (clr_all) begin
      valid_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q   <= '0;
      col_q   <= '0;
      valid_q <= '0;
    end else begin
      row_q   <= row_d;
      col_q   <= col_d;
      valid_q <= valid_d;
    end
  end

  // Data entries: per-entry clock enable, no reset needed (gated by valid)
  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (byte_en && (wcol == COL_W'(e))) begin
        data_q[e] <= byte_data;
      end
    end
  end

  assign row_o      = row_q;
  assign scan_data  = data_q[scan_idx];
  assign scan_valid = valid_q[scan_idx];

  // R7
  latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (valid_q == '0));

  // R2
  byte_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_en && !clr_all) |=> valid_q[$past(wcol)]);

  // R2
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_en |=> $stable(row_q));

endmodule

// File: rtl/pgw_commit_seq.sv
`timescale 1ns/1ps
module pgw_commit_seq
  import pgw_pkg::*;
#(
  parameter int COL_W       = 7,
  parameter int BUSY_CYCLES = 300
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_en,
  output logic             busy,
  output logic             scan_active,
  output logic [COL_W-1:0] scan_idx,
  output logic             done
);
  localparam int ROW_SIZE = 1 << COL_W;
  localparam int WAIT_CYC = (BUSY_CYCLES > ROW_SIZE) ? (BUSY_CYCLES - ROW_SIZE) : 0;
  localparam int CNT_W    = $clog2(WAIT_CYC + 2);
  localparam logic [CNT_W-1:0] WAIT_LOAD = CNT_W'((WAIT_CYC > 0) ? (WAIT_CYC - 1) : 0);

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [COL_W-1:0]  idx_q, idx_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    done    = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (commit_en) begin
          idx_d = '0;
          cnt_d = WAIT_LOAD;
          state_d = (WAIT_CYC == 0) ? SEQ_WRITE : SEQ_WAIT;
        end
      end
      SEQ_WAIT: begin
        if (cnt_q == '0) begin
          state_d = SEQ_WRITE;
          idx_d   = '0;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      SEQ_WRITE: begin
        idx_d = idx_q + COL_W'(1);
        if (idx_q == '1) begin
          state_d = SEQ_IDLE;
          done    = 1'b1;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
    end
  end

  assign busy        = (state_q != SEQ_IDLE);
  assign scan_active = (state_q == SEQ_WRITE);
  assign scan_idx    = idx_q;

  // R5
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |=> busy);

  // R5
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

endmodule

// File: rtl/pgw_page_commit.sv
`timescale 1ns/1ps
module pgw_page_commit #(
  parameter int ADDR_W      = 9,
  parameter int COL_W       = 7,
  parameter int DATA_W      = 8,
  parameter int BUSY_CYCLES = 300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_start,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              ld_byte,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              commit_req,
  input  logic              abort_req,
  output logic              busy,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int ROW_W = ADDR_W - COL_W;

  // Reset: asserted asynchronously, released on the clock
  logic rst_s1_q, rst_s2_q, rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_i_n = rst_s2_q;

  // Request arbitration: abort > commit > load, nothing while busy
  logic idle, abort_en, commit_en, load_ok, start_en, byte_en;
  logic seq_done, scan_active, scan_valid, wr_en;
  logic [COL_W-1:0]  scan_idx;
  logic [ROW_W-1:0]  row;
  logic [DATA_W-1:0] scan_data;

  assign idle      = !busy;
  assign abort_en  = idle && abort_req;
  assign commit_en = idle && commit_req && !abort_req;
  assign load_ok   = idle && !abort_req && !commit_req;
  assign start_en  = load_ok && ld_start;
  assign byte_en   = load_ok && ld_byte;

  pgw_page_latch #(
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .DATA_W(DATA_W)
  ) u_latch (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .start_en  (start_en),
    .start_addr(ld_addr),
    .byte_en   (byte_en),
    .byte_data (ld_data),
    .clr_all   (abort_en || seq_done),
    .scan_idx  (scan_idx),
    .row_o     (row),
    .scan_data (scan_data),
    .scan_valid(scan_valid)
  );

  pgw_commit_seq #(
    .COL_W      (COL_W),
    .BUSY_CYCLES(BUSY_CYCLES)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .commit_en  (commit_en),
    .busy       (busy),
    .scan_active(scan_active),
    .scan_idx   (scan_idx),
    .done       (seq_done)
  );

  assign wr_en = scan_active && scan_valid;

  pgw_byte_array #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_array (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .wr_en  (wr_en),
    .wr_addr({row, scan_idx}),
    .wr_data(scan_data),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  // R11
  abort_wins_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (idle && abort_req) |=> !busy);

  // R7
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (idle && abort_req) |=> !wr_en);

endmodule

// File: tb/test_pgw_page_commit.sv
`timescale 1ns/1ps
module test_pgw_page_commit;
  localparam int AW    = 9;
  localparam int CW    = 7;
  localparam int DW    = 8;
  localparam int BUSY  = 300;
  localparam int DEPTH = 1 << AW;
  localparam int ROWSZ = 1 << CW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ld_start, ld_byte, commit_req, abort_req;
  logic [AW-1:0] ld_addr, rd_addr;
  logic [DW-1:0] ld_data, rd_data;
  logic          busy;

  pgw_page_commit #(.ADDR_W(AW), .COL_W(CW), .DATA_W(DW), .BUSY_CYCLES(BUSY)) i_pgw_page_commit (
    .clk(clk), .rst_n(rst_n), .ld_start(ld_start), .ld_addr(ld_addr), .ld_byte(ld_byte),
    .ld_data(ld_data), .commit_req(commit_req), .abort_req(abort_req), .busy(busy),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #2 clk = ~clk;

  // Reference model built from the requirements
  logic [DW-1:0] m_arr [DEPTH];
  logic [DW-1:0] m_lat [ROWSZ];
  bit            m_val [ROWSZ];
  int            m_row, m_col;
  int            n_checks, n_errors;
  bit            finished;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cmp_array(input string req);
    int bad = 0; int first = -1; int fa = 0; int fe = 0;
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr = AW'(a);
      #0.2;
      if (rd_data !== m_arr[a]) begin
        if (bad == 0) begin first = a; fa = int'(rd_data); fe = int'(m_arr[a]); end
        bad++;
      end
    end
    check(bad == 0, req, $sformatf("array bytes wrong=%0d first at %0h", bad, first), fa, fe);
  endtask

  task automatic clr_model_latch();
    for (int i = 0; i < ROWSZ; i++) m_val[i] = 1'b0;
  endtask

  task automatic do_start(input int addr);
    @(negedge clk); ld_start = 1'b1; ld_addr = AW'(addr);
    @(negedge clk); ld_start = 1'b0;
    m_row = addr / ROWSZ; m_col = addr % ROWSZ; clr_model_latch();
  endtask

  task automatic do_byte(input logic [DW-1:0] d);
    @(negedge clk); ld_byte = 1'b1; ld_data = d;
    @(negedge clk); ld_byte = 1'b0;
    m_lat[m_col] = d; m_val[m_col] = 1'b1; m_col = (m_col + 1) % ROWSZ;
  endtask

  // Commit, count busy cycles, optionally inject requests during busy
  task automatic do_commit(input string req, input bit noise, input bit with_byte);
    int cnt = 0;
    @(negedge clk); commit_req = 1'b1;
    if (with_byte) begin ld_byte = 1'b1; ld_data = 8'h77; end
    @(negedge clk); commit_req = 1'b0; ld_byte = 1'b0;
    while (busy === 1'b1 && cnt < BUSY + 20) begin
      cnt++;
      if (noise) begin
        ld_start   = (cnt == 4);
        ld_addr    = AW'(0);
        ld_byte    = (cnt == 10) || (cnt == BUSY - 3);
        ld_data    = 8'hEE;
        abort_req  = (cnt == 20);
        commit_req = (cnt == 30);
      end
      @(negedge clk);
    end
    ld_start = 1'b0; ld_byte = 1'b0; abort_req = 1'b0; commit_req = 1'b0;
    check(cnt == BUSY, req, "busy length", cnt, BUSY);
    for (int i = 0; i < ROWSZ; i++)
      if (m_val[i]) m_arr[m_row * ROWSZ + i] = m_lat[i];
    clr_model_latch();
    cmp_array(req);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ld_start = 0; ld_byte = 0; commit_req = 0; abort_req = 0;
    ld_addr = '0; ld_data = '0; rd_addr = '0;
    for (int a = 0; a < DEPTH; a++) m_arr[a] = 8'hFF;
    clr_model_latch(); m_row = 0; m_col = 0;
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R1", "busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy === 1'b0, "R1", "busy after reset", int'(busy), 0);
    cmp_array("R1");
  endtask

  task automatic t_sequential();   // R2, R4
    do_start(9'h085);
    for (int i = 0; i < 6; i++) do_byte(8'(8'h10 + i));
    do_commit("R2", 1'b0, 1'b0);
  endtask

  task automatic t_wrap();         // R3
    do_start(9'h100);
    for (int i = 0; i < 130; i++) do_byte(8'(i * 7 + 1));
    do_commit("R3", 1'b0, 1'b0);
  endtask

  task automatic t_busy_ignore();  // R6
    do_start(9'h000);
    do_byte(8'hA0); do_byte(8'hA1); do_byte(8'hA2);
    do_commit("R6", 1'b1, 1'b0);
  endtask

  task automatic t_abort();        // R7
    do_start(9'h132);
    do_byte(8'h55); do_byte(8'h66);
    @(negedge clk); abort_req = 1'b1;
    @(negedge clk); abort_req = 1'b0;
    clr_model_latch();
    check(busy === 1'b0, "R7", "busy after abort", int'(busy), 0);
    do_commit("R7", 1'b0, 1'b0);
  endtask

  task automatic t_continue();     // R8
    do_start(9'h0C4);
    do_byte(8'h31);
    do_commit("R8", 1'b0, 1'b0);
    do_byte(8'h32);
    do_commit("R8", 1'b0, 1'b0);
  endtask

  task automatic t_restart();      // R9
    do_start(9'h005);
    do_byte(8'hC1); do_byte(8'hC2);
    do_start(9'h028);
    do_byte(8'hC3);
    do_commit("R9", 1'b0, 1'b0);
  endtask

  task automatic t_single();       // R10
    do_start(9'h1FF);
    do_byte(8'h5A);
    do_commit("R10", 1'b0, 1'b0);
  endtask

  task automatic t_priority();     // R11
    do_start(9'h18A);
    do_byte(8'hB1); do_byte(8'hB2);
    @(negedge clk); abort_req = 1'b1; commit_req = 1'b1; ld_byte = 1'b1; ld_data = 8'hBB;
    @(negedge clk); abort_req = 1'b0; commit_req = 1'b0; ld_byte = 1'b0;
    clr_model_latch();
    check(busy === 1'b0, "R11", "abort beats commit", int'(busy), 0);
    do_commit("R11", 1'b0, 1'b0);
    do_start(9'h194);
    do_byte(8'hB3);
    do_commit("R11", 1'b0, 1'b1);
  endtask

  initial begin
    #(4.0 * 150000);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    n_checks = 0; n_errors = 0; finished = 1'b0;
    t_reset();
    t_sequential();
    t_wrap();
    t_busy_ignore();
    t_abort();
    t_continue();
    t_restart();
    t_single();
    t_priority();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule